// File: doc/BRIEF.md
# Display-Priority Shared Memory Arbiter

This block sits between two bus masters and one memory controller that can work on only one transaction at a time. One master is a general-purpose processor and the other is a scan-out engine that streams pixels to a display. Both masters have separate read and write channels, each with its own valid/ready handshake. Both share a memory controller with the same channel layout, and only one transaction may be active at that controller at any moment.

The arbiter merges the four request channels (two read address, two write address) into one serialized stream. It decides the next owner in a single idle cycle and considers reads and writes together. This stops the controller from swinging back and forth between a read stream and a write stream, which would starve the display. Display reads win first, then processor reads, then display writes, then processor writes. A granted transaction keeps the memory until its final read beat or its write response has been accepted. All data and response traffic is steered to the owner, and the other master sees no ready and no valid. A configurable read-streak limit keeps a waiting write from starving for ever.

Top module: `disp_mem_arb`

## Requirements
- R1: While a transaction holds the memory, no other master's address request reaches the memory side. The memory side never receives a read address and a write address in the same cycle.
- R2: When the arbiter is idle and a display read request is pending, the display read is granted, provided R8 is not forcing a write. Its address appears on the memory read address channel in the cycle after the idle cycle.
- R3: When no display read is pending, a pending processor read is granted ahead of any pending write.
- R4: When only writes are pending, the display write is granted ahead of the processor write.
- R5: A grant lasts until the memory-side read beat with the last flag has been accepted, or until the write response has been accepted. The next grant is made in the cycle after that release.
- R6: Read data, last flag and read valid reach only the owning master. The other master's read valid stays low.
- R7: During a write, only the owner's write data is forwarded and only the owner sees write ready and the write response. The other master's write ready and response valid stay low.
- R8: A write is waiting when either write address valid is high. After STARVE_LIM read grants in a row made while a write was waiting (default 3), the next grant goes to a write, even if reads are pending. The display write is chosen first when both writes wait.
- R9: Out of reset the arbiter is idle: no memory-side address or write valid is driven, and every ready and valid towards the masters is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ar_valid | input | 1 | Processor read request valid |
| cpu_ar_ready | output | 1 | Processor read request accepted |
| cpu_ar_addr | input | ADDR_W | Processor read address |
| cpu_ar_len | input | LEN_W | Processor read beats minus one |
| cpu_r_valid | output | 1 | Read data valid to processor |
| cpu_r_ready | input | 1 | Processor accepts read data |
| cpu_r_data | output | DATA_W | Read data to processor |
| cpu_r_last | output | 1 | Final read beat to processor |
| cpu_aw_valid | input | 1 | Processor write request valid |
| cpu_aw_ready | output | 1 | Processor write request accepted |
| cpu_aw_addr | input | ADDR_W | Processor write address |
| cpu_aw_len | input | LEN_W | Processor write beats minus one |
| cpu_w_valid | input | 1 | Processor write data valid |
| cpu_w_ready | output | 1 | Processor write data accepted |
| cpu_w_data | input | DATA_W | Processor write data |
| cpu_w_last | input | 1 | Processor final write beat |
| cpu_b_valid | output | 1 | Write response valid to processor |
| cpu_b_ready | input | 1 | Processor accepts write response |
| dsp_ar_valid | input | 1 | Display read request valid |
| dsp_ar_ready | output | 1 | Display read request accepted |
| dsp_ar_addr | input | ADDR_W | Display read address |
| dsp_ar_len | input | LEN_W | Display read beats minus one |
| dsp_r_valid | output | 1 | Read data valid to display |
| dsp_r_ready | input | 1 | Display accepts read data |
| dsp_r_data | output | DATA_W | Read data to display |
| dsp_r_last | output | 1 | Final read beat to display |
| dsp_aw_valid | input | 1 | Display write request valid |
| dsp_aw_ready | output | 1 | Display write request accepted |
| dsp_aw_addr | input | ADDR_W | Display write address |
| dsp_aw_len | input | LEN_W | Display write beats minus one |
| dsp_w_valid | input | 1 | Display write data valid |
| dsp_w_ready | output | 1 | Display write data accepted |
| dsp_w_data | input | DATA_W | Display write data |
| dsp_w_last | input | 1 | Display final write beat |
| dsp_b_valid | output | 1 | Write response valid to display |
| dsp_b_ready | input | 1 | Display accepts write response |
| mem_ar_valid | output | 1 | Read request to memory |
| mem_ar_ready | input | 1 | Memory accepts read request |
| mem_ar_addr | output | ADDR_W | Read address to memory |
| mem_ar_len | output | LEN_W | Read beats minus one to memory |
| mem_r_valid | input | 1 | Read data valid from memory |
| mem_r_ready | output | 1 | Read data accepted by owner |
| mem_r_data | input | DATA_W | Read data from memory |
| mem_r_last | input | 1 | Final read beat from memory |
| mem_aw_valid | output | 1 | Write request to memory |
| mem_aw_ready | input | 1 | Memory accepts write request |
| mem_aw_addr | output | ADDR_W | Write address to memory |
| mem_aw_len | output | LEN_W | Write beats minus one to memory |
| mem_w_valid | output | 1 | Write data valid to memory |
| mem_w_ready | input | 1 | Memory accepts write data |
| mem_w_data | output | DATA_W | Write data to memory |
| mem_w_last | output | 1 | Final write beat to memory |
| mem_b_valid | input | 1 | Write response from memory |
| mem_b_ready | output | 1 | Write response accepted by owner |

## Verification
The grant decision is driven through every mix of the four request lines that separates one priority rule from another. Pairs such as display read with processor read, processor read with display write, and the two writes each isolate a single ranking. The all-requests case shows that the top rank dominates. Full transactions check the data path: a multi-beat display read while a processor read waits shows that the lock holds and that read data is steered only to the owner. A two-beat processor write shows that write data and the write response go only to the owner. A long run of display reads against a parked processor write shows exactly where the streak limit flips the grant to the write.

// File: rtl/disp_mem_arb.sv
module disp_mem_arb #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 8,
  parameter int STARVE_LIM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ar_valid,
  output logic              cpu_ar_ready,
  input  logic [ADDR_W-1:0] cpu_ar_addr,
  input  logic [LEN_W-1:0]  cpu_ar_len,
  output logic              cpu_r_valid,
  input  logic              cpu_r_ready,
  output logic [DATA_W-1:0] cpu_r_data,
  output logic              cpu_r_last,
  input  logic              cpu_aw_valid,
  output logic              cpu_aw_ready,
  input  logic [ADDR_W-1:0] cpu_aw_addr,
  input  logic [LEN_W-1:0]  cpu_aw_len,
  input  logic              cpu_w_valid,
  output logic              cpu_w_ready,
  input  logic [DATA_W-1:0] cpu_w_data,
  input  logic              cpu_w_last,
  output logic              cpu_b_valid,
  input  logic              cpu_b_ready,
  input  logic              dsp_ar_valid,
  output logic              dsp_ar_ready,
  input  logic [ADDR_W-1:0] dsp_ar_addr,
  input  logic [LEN_W-1:0]  dsp_ar_len,
  output logic              dsp_r_valid,
  input  logic              dsp_r_ready,
  output logic [DATA_W-1:0] dsp_r_data,
  output logic              dsp_r_last,
  input  logic              dsp_aw_valid,
  output logic              dsp_aw_ready,
  input  logic [ADDR_W-1:0] dsp_aw_addr,
  input  logic [LEN_W-1:0]  dsp_aw_len,
  input  logic              dsp_w_valid,
  output logic              dsp_w_ready,
  input  logic [DATA_W-1:0] dsp_w_data,
  input  logic              dsp_w_last,
  output logic              dsp_b_valid,
  input  logic              dsp_b_ready,
  output logic              mem_ar_valid,
  input  logic              mem_ar_ready,
  output logic [ADDR_W-1:0] mem_ar_addr,
  output logic [LEN_W-1:0]  mem_ar_len,
  input  logic              mem_r_valid,
  output logic              mem_r_ready,
  input  logic [DATA_W-1:0] mem_r_data,
  input  logic              mem_r_last,
  output logic              mem_aw_valid,
  input  logic              mem_aw_ready,
  output logic [ADDR_W-1:0] mem_aw_addr,
  output logic [LEN_W-1:0]  mem_aw_len,
  output logic              mem_w_valid,
  input  logic              mem_w_ready,
  output logic [DATA_W-1:0] mem_w_data,
  output logic              mem_w_last,
  input  logic              mem_b_valid,
  output logic              mem_b_ready
);

  localparam int STRK_W = $clog2(STARVE_LIM + 1);
  localparam logic [STRK_W-1:0] STRK_MAX = STRK_W'(STARVE_LIM);

  logic              busy, own_dsp, is_wr, addr_done;
  logic [STRK_W-1:0] streak;

  logic wr_wait, force_wr, pick_any, pick_dsp, pick_wr;
  logic rd_phase, wr_phase, release_now;

  assign wr_wait  = cpu_aw_valid | dsp_aw_valid;
  assign force_wr = wr_wait && (streak == STRK_MAX);
  assign pick_any = wr_wait | cpu_ar_valid | dsp_ar_valid;

  always_comb begin
    pick_wr  = 1'b0;
    pick_dsp = 1'b0;
    if (force_wr) begin
      pick_wr  = 1'b1;
      pick_dsp = dsp_aw_valid;
    end else if (dsp_ar_valid) begin
      pick_dsp = 1'b1;
    end else if (cpu_ar_valid) begin
      pick_dsp = 1'b0;
    end else if (dsp_aw_valid) begin
      pick_wr  = 1'b1;
      pick_dsp = 1'b1;
    end else begin
      pick_wr  = 1'b1;
    end
  end

  assign rd_phase = busy && !is_wr;
  assign wr_phase = busy &&  is_wr;

  assign release_now = (rd_phase && mem_r_valid && mem_r_ready && mem_r_last) ||
                       (wr_phase && mem_b_valid && mem_b_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      own_dsp   <= 1'b0;
      is_wr     <= 1'b0;
      addr_done <= 1'b0;
      streak    <= '0;
    end else if (!busy) begin
      if (pick_any) begin
        busy      <= 1'b1;
        own_dsp   <= pick_dsp;
        is_wr     <= pick_wr;
        addr_done <= 1'b0;
        if (pick_wr)
          streak <= '0;
        else if (!wr_wait)
          streak <= '0;
        else if (streak != STRK_MAX)
          streak <= streak + 1'b1;
      end
    end else begin
      if ((mem_ar_valid && mem_ar_ready) || (mem_aw_valid && mem_aw_ready))
        addr_done <= 1'b1;
      if (release_now) begin
        busy      <= 1'b0;
        addr_done <= 1'b0;
      end
    end
  end

  // Memory-side address channels
  assign mem_ar_valid = rd_phase && !addr_done && (own_dsp ? dsp_ar_valid : cpu_ar_valid);
  assign mem_ar_addr  = own_dsp ? dsp_ar_addr : cpu_ar_addr;
  assign mem_ar_len   = own_dsp ? dsp_ar_len  : cpu_ar_len;
  assign mem_aw_valid = wr_phase && !addr_done && (own_dsp ? dsp_aw_valid : cpu_aw_valid);
  assign mem_aw_addr  = own_dsp ? dsp_aw_addr : cpu_aw_addr;
  assign mem_aw_len   = own_dsp ? dsp_aw_len  : cpu_aw_len;

  assign cpu_ar_ready = rd_phase && !own_dsp && !addr_done && mem_ar_ready;
  assign dsp_ar_ready = rd_phase &&  own_dsp && !addr_done && mem_ar_ready;
  assign cpu_aw_ready = wr_phase && !own_dsp && !addr_done && mem_aw_ready;
  assign dsp_aw_ready = wr_phase &&  own_dsp && !addr_done && mem_aw_ready;

  // Read return steering
  assign mem_r_ready = rd_phase && (own_dsp ? dsp_r_ready : cpu_r_ready);
  assign cpu_r_valid = rd_phase && !own_dsp && mem_r_valid;
  assign dsp_r_valid = rd_phase &&  own_dsp && mem_r_valid;
  assign cpu_r_data  = mem_r_data;
  assign dsp_r_data  = mem_r_data;
  assign cpu_r_last  = mem_r_last;
  assign dsp_r_last  = mem_r_last;

  // Write data and response steering
  assign mem_w_valid = wr_phase && (own_dsp ? dsp_w_valid : cpu_w_valid);
  assign mem_w_data  = own_dsp ? dsp_w_data : cpu_w_data;
  assign mem_w_last  = own_dsp ? dsp_w_last : cpu_w_last;
  assign cpu_w_ready = wr_phase && !own_dsp && mem_w_ready;
  assign dsp_w_ready = wr_phase &&  own_dsp && mem_w_ready;

  assign mem_b_ready = wr_phase && (own_dsp ? dsp_b_ready : cpu_b_ready);
  assign cpu_b_valid = wr_phase && !own_dsp && mem_b_valid;
  assign dsp_b_valid = wr_phase &&  own_dsp && mem_b_valid;

  // R1
  one_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_ar_valid && mem_aw_valid));

  // R1
  wr_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_aw_valid |-> !mem_r_ready);

  // R2
  dsp_rd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dsp_ar_valid && !force_wr) |=> (busy && own_dsp && !is_wr));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !release_now) |=> (busy && $stable(own_dsp) && $stable(is_wr)));

  // R6
  resp_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_r_valid, dsp_r_valid, cpu_b_valid, dsp_b_valid}));

  // R8
  starve_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && force_wr) |=> (busy && is_wr));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(cpu_ar_ready || dsp_ar_ready || cpu_aw_ready || dsp_aw_ready ||
                cpu_w_ready || dsp_w_ready || mem_w_valid));

endmodule

// File: tb/test_disp_mem_arb.sv
`timescale 1ns/1ps
module test_disp_mem_arb;
  localparam int AW = 32, DW = 32, LW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cpu_ar_valid = 0, cpu_ar_ready; logic [AW-1:0] cpu_ar_addr = 0; logic [LW-1:0] cpu_ar_len = 0;
  logic cpu_r_valid, cpu_r_ready = 0, cpu_r_last; logic [DW-1:0] cpu_r_data;
  logic cpu_aw_valid = 0, cpu_aw_ready; logic [AW-1:0] cpu_aw_addr = 0; logic [LW-1:0] cpu_aw_len = 0;
  logic cpu_w_valid = 0, cpu_w_ready, cpu_w_last = 0; logic [DW-1:0] cpu_w_data = 0;
  logic cpu_b_valid, cpu_b_ready = 0;
  logic dsp_ar_valid = 0, dsp_ar_ready; logic [AW-1:0] dsp_ar_addr = 0; logic [LW-1:0] dsp_ar_len = 0;
  logic dsp_r_valid, dsp_r_ready = 0, dsp_r_last; logic [DW-1:0] dsp_r_data;
  logic dsp_aw_valid = 0, dsp_aw_ready; logic [AW-1:0] dsp_aw_addr = 0; logic [LW-1:0] dsp_aw_len = 0;
  logic dsp_w_valid = 0, dsp_w_ready, dsp_w_last = 0; logic [DW-1:0] dsp_w_data = 0;
  logic dsp_b_valid, dsp_b_ready = 0;
  logic mem_ar_valid, mem_ar_ready = 1; logic [AW-1:0] mem_ar_addr; logic [LW-1:0] mem_ar_len;
  logic mem_r_valid = 0, mem_r_ready, mem_r_last = 0; logic [DW-1:0] mem_r_data = 0;
  logic mem_aw_valid, mem_aw_ready = 1; logic [AW-1:0] mem_aw_addr; logic [LW-1:0] mem_aw_len;
  logic mem_w_valid, mem_w_ready = 1, mem_w_last; logic [DW-1:0] mem_w_data;
  logic mem_b_valid = 0, mem_b_ready;

  disp_mem_arb #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .STARVE_LIM(3)) i_disp_mem_arb (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // {dsp_ar, cpu_ar, dsp_aw, cpu_aw} request mix, expected address granted first
  // Addresses: dsp read 1000, cpu read 2000, dsp write 3000, cpu write 4000
  localparam logic [35:0] VEC [10] = '{
    {4'b1000, 32'h1000}, {4'b0100, 32'h2000}, {4'b0010, 32'h3000},
    {4'b0001, 32'h4000}, {4'b1100, 32'h1000}, {4'b0110, 32'h2000},
    {4'b0011, 32'h3000}, {4'b1111, 32'h1000}, {4'b0101, 32'h2000},
    {4'b1010, 32'h1000}};

  function automatic logic [31:0] seen();
    return mem_ar_valid ? mem_ar_addr : (mem_aw_valid ? mem_aw_addr : 32'h0);
  endfunction

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    dsp_ar_addr = 32'h1000; cpu_ar_addr = 32'h2000;
    dsp_aw_addr = 32'h3000; cpu_aw_addr = 32'h4000;
    do_reset();
    // R9 reset state
    chk(!mem_ar_valid && !mem_aw_valid && !mem_w_valid, "R9 mem valids", {mem_ar_valid, mem_aw_valid, mem_w_valid}, 0);
    chk(!cpu_ar_ready && !dsp_ar_ready && !cpu_aw_ready && !dsp_aw_ready, "R9 readies", 0, 0);

    // R2 R3 R4 priority table
    foreach (VEC[i]) begin
      do_reset();
      {dsp_ar_valid, cpu_ar_valid, dsp_aw_valid, cpu_aw_valid} = VEC[i][35:32];
      @(posedge clk); @(negedge clk);
      chk(seen() == VEC[i][31:0], "R2/R3/R4 priority", seen(), VEC[i][31:0]);
      chk(!(mem_ar_valid && mem_aw_valid), "R1 single request", {mem_ar_valid, mem_aw_valid}, 0);
      {dsp_ar_valid, cpu_ar_valid, dsp_aw_valid, cpu_aw_valid} = 4'b0;
    end

    // R5 R6 display read of 4 beats, cpu read waiting
    do_reset();
    dsp_r_ready = 1; cpu_r_ready = 1; cpu_b_ready = 1; dsp_b_ready = 1;
    dsp_ar_len = 3; dsp_ar_valid = 1; cpu_ar_valid = 1;
    @(posedge clk); @(negedge clk);
    chk(dsp_ar_ready && !cpu_ar_ready, "R1 address ready to owner", {dsp_ar_ready, cpu_ar_ready}, 2'b10);
    @(posedge clk); @(negedge clk);
    dsp_ar_valid = 0;
    #1;
    chk(!mem_ar_valid, "R1 locked while reading", mem_ar_valid, 0);
    for (int b = 0; b < 4; b++) begin
      mem_r_valid = 1; mem_r_data = 32'hA0 + b; mem_r_last = (b == 3);
      #1;
      chk(dsp_r_valid && dsp_r_data == 32'hA0 + b && !cpu_r_valid, "R6 read routed to display", dsp_r_data, 32'hA0 + b);
      @(posedge clk); @(negedge clk);
    end
    mem_r_valid = 0; mem_r_last = 0;
    #1;
    chk(!mem_ar_valid, "R5 idle cycle after release", mem_ar_valid, 0);
    @(posedge clk); @(negedge clk);
    chk(mem_ar_valid && mem_ar_addr == 32'h2000, "R5 cpu granted after release", seen(), 32'h2000);
    @(posedge clk); @(negedge clk);
    cpu_ar_valid = 0; mem_r_valid = 1; mem_r_last = 1; mem_r_data = 32'h77;
    #1;
    chk(cpu_r_valid && cpu_r_last && !dsp_r_valid, "R6 read routed to cpu", {cpu_r_valid, dsp_r_valid}, 2'b10);
    @(posedge clk); @(negedge clk);
    mem_r_valid = 0; mem_r_last = 0;

    // R7 cpu write of 2 beats
    do_reset();
    cpu_aw_len = 1; cpu_aw_valid = 1; cpu_w_valid = 1; cpu_w_data = 32'h55; cpu_w_last = 0;
    dsp_w_valid = 1; dsp_w_data = 32'hEE;
    @(posedge clk); @(negedge clk);
    chk(mem_aw_valid && mem_aw_addr == 32'h4000, "R4 cpu write address", seen(), 32'h4000);
    chk(mem_w_valid && mem_w_data == 32'h55, "R7 owner write data", mem_w_data, 32'h55);
    chk(cpu_w_ready && !dsp_w_ready, "R7 write ready to owner only", {cpu_w_ready, dsp_w_ready}, 2'b10);
    @(posedge clk); @(negedge clk);
    cpu_aw_valid = 0; cpu_w_data = 32'h56; cpu_w_last = 1;
    #1;
    chk(mem_w_last && mem_w_data == 32'h56 && !mem_aw_valid, "R7 last write beat", mem_w_data, 32'h56);
    @(posedge clk); @(negedge clk);
    cpu_w_valid = 0; cpu_w_last = 0; dsp_w_valid = 0; mem_b_valid = 1;
    #1;
    chk(cpu_b_valid && !dsp_b_valid, "R7 response to owner only", {cpu_b_valid, dsp_b_valid}, 2'b10);
    @(posedge clk); @(negedge clk);
    mem_b_valid = 0;
    #1;
    chk(!cpu_b_valid && !mem_aw_valid && !mem_ar_valid, "R5 released after response", cpu_b_valid, 0);

    // R8 streak of display reads against a parked cpu write
    do_reset();
    cpu_aw_valid = 1; cpu_aw_len = 0; dsp_ar_len = 0;
    for (int k = 0; k < 4; k++) begin
      dsp_ar_valid = 1;
      @(posedge clk); @(negedge clk);
      if (k < 3) begin
        chk(mem_ar_valid && mem_ar_addr == 32'h1000, "R8 read before limit", seen(), 32'h1000);
        @(posedge clk); @(negedge clk);
        dsp_ar_valid = 0; mem_r_valid = 1; mem_r_last = 1;
        @(posedge clk); @(negedge clk);
        mem_r_valid = 0; mem_r_last = 0;
      end else begin
        chk(mem_aw_valid && mem_aw_addr == 32'h4000 && !mem_ar_valid, "R8 write forced at limit", seen(), 32'h4000);
      end
    end
    dsp_ar_valid = 0; cpu_aw_valid = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule